// File: doc/BRIEF.md
# Multiplexed DRAM Strobe Controller

This block runs the strobe sequence for one or two banks of DRAM modules behind a 68000-style asynchronous bus. When the address decoder flags a RAM cycle and the bus address strobe falls, the controller first drives the row strobe, then flips the row/column address multiplexer, and then drives the column strobe on the byte lanes the bus asks for. All strobes are released when the address strobe rises, and the row strobe then stays high long enough to precharge.

Two configuration inputs select the module size and whether a second bank is fitted. Together they decide which address line feeds the shared RA7 multiplexed address bit in each phase, and which address line picks the bank. A ROM select or a startup inhibit keeps the DRAM strobes quiet and the RAM data buffer off. The write enable is taken from the bus read/write line when a cycle starts and is held for the whole cycle.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: With `as_n` low, `ram_sel` high, `rom_sel` low and `boot_inhibit` low at a rising edge, `ras_n` goes low after that edge with `mux_col` at 0. `mux_col` goes to 1 one clock later. The column strobes go low one clock after that, and never before `mux_col` is 1.
- R2: While the column phase lasts, each `*_lo_n` strobe follows `lds_n` and each `*_hi_n` strobe follows `uds_n`, one clock late. A byte access therefore drives only one lane.
- R3: With `dual_bank` at 0, only bank 0 strobes are used. With `dual_bank` at 1, the bank is captured at the start of the cycle: with `mod_size`=0 it is A17 (`abit[2]`), and with `mod_size`=1 it is A19 (`abit[3]`). The value 1 selects bank 1. The two banks are never strobed at once.
- R4: With `mod_size`=0 (smallest modules), `ra7` equals A9 (`abit[0]`) while `mux_col`=0 and A10 (`abit[1]`) while `mux_col`=1.
- R5: With `mod_size`=1 (256K modules), `ra7` equals A17 (`abit[2]`) while `mux_col`=0 and A9 (`abit[0]`) while `mux_col`=1.
- R6: A high `as_n` sampled at an edge releases every strobe after that edge. Once `ras_n` rises it stays high for at least two clocks before it can fall again.
- R7: While `boot_inhibit` is high, `ras_n` and all column strobes are high from the following clock on. This also cuts a cycle already under way.
- R8: A cycle with `rom_sel` high never strobes DRAM, and `buf_en_n` stays high.
- R9: `ram_we_n` takes the value of `rw` (1 = read) when a cycle starts and holds it to the end of the cycle. Outside a cycle it is 1.
- R10: `buf_en_n` is low from the row phase through the column phase of a RAM cycle, and high otherwise, including in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| as_n | input | 1 | Bus address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | Bus direction, 1 = read, 0 = write |
| ram_sel | input | 1 | Decoder flags a RAM access |
| rom_sel | input | 1 | Decoder flags a ROM access |
| boot_inhibit | input | 1 | Startup inhibit of all DRAM strobes |
| mod_size | input | 1 | 0 = smallest modules, 1 = 256K modules |
| dual_bank | input | 1 | 1 when a second bank is fitted |
| abit | input | 4 | Address bits {A19, A17, A10, A9} |
| ras_n | output | 1 | Row strobe, active low |
| mux_col | output | 1 | Address multiplexer select, 1 = column |
| cas0_lo_n | output | 1 | Bank 0 low-byte column strobe |
| cas0_hi_n | output | 1 | Bank 0 high-byte column strobe |
| cas1_lo_n | output | 1 | Bank 1 low-byte column strobe |
| cas1_hi_n | output | 1 | Bank 1 high-byte column strobe |
| ram_we_n | output | 1 | RAM write enable, active low |
| buf_en_n | output | 1 | RAM data buffer enable, active low |
| ra7 | output | 1 | Multiplexed address bit 7 |

## Verification
The release on a rising address strobe and the start of the next access can fall in the same few cycles. The bench provokes this by dropping `as_n` again at once after a release. It judges the result by checking that `ras_n` stays high for two sampled clocks and falls only on the third. A second overlap is an inhibit or ROM select arriving while a cycle is already in its row or column phase. That case is judged by every strobe being high one clock later, with no column strobe ever seen.

// File: rtl/dsc_pkg.sv
// Shared types for the DRAM strobe controller.
// Assumes exactly two banks of two byte lanes each.
package dsc_pkg;
    localparam int NUM_BANKS = 2;
    localparam int NUM_LANES = 2;
    localparam int NUM_CAS   = NUM_BANKS * NUM_LANES;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_CAS  = 3'd3,
        ST_PRE  = 3'd4
    } dsc_state_e;

    typedef enum logic {
        SIZE_SMALL = 1'b0,
        SIZE_256K  = 1'b1
    } dsc_size_e;

    // True while a RAM cycle holds the row strobe.
    function automatic logic dsc_active(dsc_state_e s);
        return (s == ST_ROW) || (s == ST_COL) || (s == ST_CAS);
    endfunction
endpackage

// File: rtl/dsc_seq.sv
// Cycle sequencer: idle -> row -> column switch -> column strobe -> precharge.
// Assumes the decoder selects are stable while as_n is low.
module dsc_seq
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       ram_sel,
    input  logic       rom_sel,
    input  logic       boot_inhibit,
    output dsc_state_e state_d,
    output logic       start
);
    dsc_state_e state_q;
    logic       abort;

    // Begin/abort conditions for a RAM cycle.
    always_comb begin
        start = (state_q == ST_IDLE) && !as_n && ram_sel && !rom_sel && !boot_inhibit;
        abort = as_n || rom_sel || boot_inhibit;
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_ROW;
            ST_ROW:  state_d = abort ? ST_PRE : ST_COL;
            ST_COL:  state_d = abort ? ST_PRE : ST_CAS;
            ST_CAS:  if (abort) state_d = ST_PRE;
            ST_PRE:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/dsc_bank_sel.sv
// Captures the bank index at cycle start from the size-dependent address bit.
// Assumes configuration inputs are static during a cycle.
module dsc_bank_sel
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dual_bank,
    input  logic mod_size,
    input  logic a17,
    input  logic a19,
    output logic bank_q
);
    logic bank_d;

    // Bank decode: single bank always 0, else size picks the address line.
    always_comb begin
        if (!dual_bank)                        bank_d = 1'b0;
        else if (dsc_size_e'(mod_size) == SIZE_256K) bank_d = a19;
        else                                   bank_d = a17;
    end

    // Hold the bank for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     bank_q <= 1'b0;
        else if (start) bank_q <= bank_d;
    end
endmodule

// File: rtl/dsc_ra7_mux.sv
// Selects the source of multiplexed address bit 7 for row and column phases.
// Assumes col_phase comes from the registered multiplexer select.
module dsc_ra7_mux
    import dsc_pkg::*;
(
    input  logic mod_size,
    input  logic col_phase,
    input  logic a9,
    input  logic a10,
    input  logic a17,
    output logic ra7
);
    logic row_src;
    logic col_src;

    // Per-size sources for each phase.
    always_comb begin
        if (dsc_size_e'(mod_size) == SIZE_256K) begin
            row_src = a17;
            col_src = a9;
        end else begin
            row_src = a9;
            col_src = a10;
        end
        ra7 = col_phase ? col_src : row_src;
    end
endmodule

// File: rtl/dsc_strobe_out.sv
// Registered strobe drivers: row strobe, mux select, buffer, write enable and
// per-bank byte-lane column strobes. Assumes bank is valid before column phase.
module dsc_strobe_out
    import dsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  dsc_state_e         state_d,
    input  logic               start,
    input  logic               rw,
    input  logic               uds_n,
    input  logic               lds_n,
    input  logic               bank,
    output logic               ras_n,
    output logic               mux_col,
    output logic               buf_en_n,
    output logic               ram_we_n,
    output logic [NUM_CAS-1:0] cas_n
);
    logic nxt_active;
    logic nxt_colsel;
    logic nxt_cas;

    // Phase flags for the coming clock.
    always_comb begin
        nxt_active = dsc_active(state_d);
        nxt_colsel = (state_d == ST_COL) || (state_d == ST_CAS);
        nxt_cas    = (state_d == ST_CAS);
    end

    // Row strobe, mux select and buffer enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n    <= 1'b1;
            mux_col  <= 1'b0;
            buf_en_n <= 1'b1;
        end else begin
            ras_n    <= !nxt_active;
            mux_col  <= nxt_colsel;
            buf_en_n <= !nxt_active;
        end
    end

    // Write enable captured at start, held to the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          ram_we_n <= 1'b1;
        else if (start)      ram_we_n <= rw;
        else if (!nxt_active) ram_we_n <= 1'b1;
    end

    // Column strobes, one pair of byte lanes per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        // Bank match for this pair.
        always_comb hit = nxt_cas && (bank == b[0]);
        // Lane registers: low follows lds_n, high follows uds_n.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cas_n[b*NUM_LANES]     <= 1'b1;
                cas_n[b*NUM_LANES + 1] <= 1'b1;
            end else begin
                cas_n[b*NUM_LANES]     <= !(hit && !lds_n);
                cas_n[b*NUM_LANES + 1] <= !(hit && !uds_n);
            end
        end
    end
endmodule

// File: rtl/dram_strobe_ctrl.sv
// Top of the DRAM strobe controller. Connects sequencer, bank capture,
// RA7 multiplexer and strobe drivers. abit carries {A19, A17, A10, A9}.
module dram_strobe_ctrl
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       uds_n,
    input  logic       lds_n,
    input  logic       rw,
    input  logic       ram_sel,
    input  logic       rom_sel,
    input  logic       boot_inhibit,
    input  logic       mod_size,
    input  logic       dual_bank,
    input  logic [3:0] abit,
    output logic       ras_n,
    output logic       mux_col,
    output logic       cas0_lo_n,
    output logic       cas0_hi_n,
    output logic       cas1_lo_n,
    output logic       cas1_hi_n,
    output logic       ram_we_n,
    output logic       buf_en_n,
    output logic       ra7
);
    dsc_state_e         state_d;
    logic               start;
    logic               bank;
    logic [NUM_CAS-1:0] cas_n;

    dsc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_n         (as_n),
        .ram_sel      (ram_sel),
        .rom_sel      (rom_sel),
        .boot_inhibit (boot_inhibit),
        .state_d      (state_d),
        .start        (start)
    );

    dsc_bank_sel u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dual_bank (dual_bank),
        .mod_size  (mod_size),
        .a17       (abit[2]),
        .a19       (abit[3]),
        .bank_q    (bank)
    );

    dsc_ra7_mux u_ra7 (
        .mod_size  (mod_size),
        .col_phase (mux_col),
        .a9        (abit[0]),
        .a10       (abit[1]),
        .a17       (abit[2]),
        .ra7       (ra7)
    );

    dsc_strobe_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_d  (state_d),
        .start    (start),
        .rw       (rw),
        .uds_n    (uds_n),
        .lds_n    (lds_n),
        .bank     (bank),
        .ras_n    (ras_n),
        .mux_col  (mux_col),
        .buf_en_n (buf_en_n),
        .ram_we_n (ram_we_n),
        .cas_n    (cas_n)
    );

    // Map the strobe vector onto named pins.
    always_comb begin
        cas0_lo_n = cas_n[0];
        cas0_hi_n = cas_n[1];
        cas1_lo_n = cas_n[2];
        cas1_hi_n = cas_n[3];
    end
endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
// Protocol checker for the DRAM strobe controller, bound to the top.
module dram_strobe_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic rom_sel,
    input logic boot_inhibit,
    input logic ras_n,
    input logic mux_col,
    input logic cas0_lo_n,
    input logic cas0_hi_n,
    input logic cas1_lo_n,
    input logic cas1_hi_n,
    input logic ram_we_n,
    input logic buf_en_n
);
    logic b0_on, b1_on, any_cas, all_off;

    always_comb begin
        b0_on   = !cas0_lo_n || !cas0_hi_n;
        b1_on   = !cas1_lo_n || !cas1_hi_n;
        any_cas = b0_on || b1_on;
        all_off = ras_n && !any_cas;
    end

    assert_cas_in_col_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_cas |-> (!ras_n && mux_col));
    assert_cas_after_switch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_cas) |-> $past(mux_col));
    assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(b0_on && b1_on));
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> all_off);
    assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_inhibit |=> all_off);
    assert_rom_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |=> (all_off && buf_en_n));
    assert_we_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cas && $past(any_cas)) |-> $stable(ram_we_n));
endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .as_n         (as_n),
    .rom_sel      (rom_sel),
    .boot_inhibit (boot_inhibit),
    .ras_n        (ras_n),
    .mux_col      (mux_col),
    .cas0_lo_n    (cas0_lo_n),
    .cas0_hi_n    (cas0_hi_n),
    .cas1_lo_n    (cas1_lo_n),
    .cas1_hi_n    (cas1_hi_n),
    .ram_we_n     (ram_we_n),
    .buf_en_n     (buf_en_n)
);

// File: tb/dram_strobe_ctrl_bench.sv
module dram_strobe_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic ram_sel = 1'b0, rom_sel = 1'b0, boot_inhibit = 1'b0;
    logic mod_size = 1'b0, dual_bank = 1'b0;
    logic [3:0] abit = 4'h0;
    logic ras_n, mux_col, cas0_lo_n, cas0_hi_n, cas1_lo_n, cas1_hi_n;
    logic ram_we_n, buf_en_n, ra7;
    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dram_strobe_ctrl u_dram_strobe_ctrl (.*);

    // Vector: config, direction, lanes, abit {A19,A17,A10,A9}, expected RA7 and bank.
    typedef struct packed {
        logic       mod;
        logic       dual;
        logic       rw;
        logic       uds_n;
        logic       lds_n;
        logic [3:0] abit;
        logic       exp_row;
        logic       exp_col;
        logic       exp_bank;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0110, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0101, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1101, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0011, 1'b1, 1'b1, 1'b0}
    };

    function automatic logic [3:0] cas_vec();
        return {cas1_hi_n, cas1_lo_n, cas0_hi_n, cas0_lo_n};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
        end
    end

    task automatic run_vec(input vec_t v);
        logic [3:0] exp_cas;
        string sz;
        sz = v.mod ? "R5" : "R4";
        exp_cas = 4'hF;
        exp_cas[v.exp_bank*2]     = v.lds_n;
        exp_cas[v.exp_bank*2 + 1] = v.uds_n;
        mod_size = v.mod; dual_bank = v.dual; rw = v.rw;
        uds_n = v.uds_n; lds_n = v.lds_n; abit = v.abit;
        ram_sel = 1'b1; as_n = 1'b0;
        @(negedge clk);
        chk("R1 ras row phase", ras_n, 0);
        chk("R1 mux row phase", mux_col, 0);
        chk("R1 no cas in row phase", cas_vec(), 15);
        chk({sz, " ra7 row"}, ra7, v.exp_row);
        chk("R9 we_n", ram_we_n, v.rw);
        chk("R10 buffer on", buf_en_n, 0);
        @(negedge clk);
        chk("R1 mux col phase", mux_col, 1);
        chk("R1 no cas before column strobe", cas_vec(), 15);
        chk({sz, " ra7 col"}, ra7, v.exp_col);
        @(negedge clk);
        chk("R2 R3 cas lanes and bank", cas_vec(), exp_cas);
        chk("R9 we_n held", ram_we_n, v.rw);
        as_n = 1'b1;
        @(negedge clk);
        chk("R6 ras released", ras_n, 1);
        chk("R6 cas released", cas_vec(), 15);
        chk("R10 buffer off", buf_en_n, 1);
        chk("R9 we_n idle", ram_we_n, 1);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset ras", ras_n, 1);
        chk("R10 reset cas", cas_vec(), 15);
        chk("R10 reset buf", buf_en_n, 1);
        chk("R9 reset we_n", ram_we_n, 1);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R2: lane follows strobe changes in the column phase.
        mod_size = 1'b0; dual_bank = 1'b0; abit = 4'h0; rw = 1'b0;
        uds_n = 1'b0; lds_n = 1'b0; ram_sel = 1'b1; as_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 both lanes", cas_vec(), 4'b1100);
        lds_n = 1'b1;
        @(negedge clk);
        chk("R2 low lane dropped", cas_vec(), 4'b1101);

        // R6: immediate re-request after release.
        as_n = 1'b1;
        @(negedge clk);
        chk("R6 release", ras_n, 1);
        as_n = 1'b0; lds_n = 1'b0;
        @(negedge clk);
        chk("R6 precharge clock 2", ras_n, 1);
        @(negedge clk);
        chk("R6 ras again after precharge", ras_n, 0);
        as_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: no cycle without RAM select.
        ram_sel = 1'b0; as_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 no ras without ram_sel", ras_n, 1);
        as_n = 1'b1;
        @(negedge clk);

        // R7: inhibit from the start.
        ram_sel = 1'b1; boot_inhibit = 1'b1; as_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 ras held off", ras_n, 1);
        chk("R7 cas held off", cas_vec(), 15);
        as_n = 1'b1; boot_inhibit = 1'b0;
        repeat (2) @(negedge clk);

        // R7: inhibit mid-cycle.
        as_n = 1'b0;
        @(negedge clk);
        chk("R7 cycle started", ras_n, 0);
        boot_inhibit = 1'b1;
        @(negedge clk);
        chk("R7 cut ras", ras_n, 1);
        chk("R7 cut cas", cas_vec(), 15);
        @(negedge clk);
        chk("R7 still off", cas_vec(), 15);
        as_n = 1'b1; boot_inhibit = 1'b0;
        repeat (2) @(negedge clk);

        // R8: ROM cycle, with and without a stray RAM select.
        rom_sel = 1'b1; ram_sel = 1'b0; as_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 rom ras", ras_n, 1);
        chk("R8 rom buf", buf_en_n, 1);
        ram_sel = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 rom overrides ram_sel", ras_n, 1);
        chk("R8 rom cas", cas_vec(), 15);
        chk("R8 rom buf held", buf_en_n, 1);
        as_n = 1'b1; rom_sel = 1'b0;
        repeat (2) @(negedge clk);

        // R6: abort in row phase.
        as_n = 1'b0;
        @(negedge clk);
        as_n = 1'b1;
        @(negedge clk);
        chk("R6 abort in row phase", ras_n, 1);
        chk("R6 abort mux", mux_col, 0);

        summary();
    end
endmodule